// File: doc/BRIEF.md
# Serial ADC Result Readout Sequencer

This block fetches conversion results from a serial delta-sigma converter over a four-wire SPI link. When enabled, it pulls chip select low and watches the converter's data-out line. The converter pulls that line low to show that a new conversion is ready. After that falling edge, the block runs a fixed byte sequence with chip select held low for the whole exchange. It sets the upper register address, issues a read command for the multi-byte result, and shifts the result in. It then repeats the same two steps for the channel status register.

At the end of the exchange the block does one of two things. If the status byte reports a result that was not ready or was already read, the block raises an error flag and keeps its previous result. Otherwise it updates the result and pulses a valid strobe. After a completed exchange, chip select stays high for a programmable gap before the next one can begin. If no data-ready edge arrives within a programmable number of cycles, the block gives up, raises a timeout flag and returns to idle.

All logic runs on the system clock. MISO passes through a two-flop synchronizer, and SCLK is a registered output driven from a divide counter, so no logic is clocked from the divided clock.

Top module: `adc_rdout_seq`

## Requirements
- R1: After reset, csb and sclk are high, and result_vld, err_stale, timeout and result are all zero.
- R2: sclk idles high. Each bit starts with a falling sclk edge, at which mosi changes. miso is sampled at the following rising edge. Bytes go most significant bit first, and each sclk low phase lasts exactly HALF_DIV clock cycles.
- R3: With enable high in idle, csb goes low and no sclk edge occurs until a falling edge has been seen on miso.
- R4: The result access sends three bytes: 0x10, then the upper address byte {5'b0, DATA_ADDR[6:4]}, then the read instruction {1'b1, RES_BYTES-1 in bits 6:5, 1'b0, DATA_ADDR[3:0]}. With the defaults this gives 0x10, 0x01, 0xCA.
- R5: During the RES_BYTES result data bytes, mosi carries all zeros. The result is assembled with the first received byte as its most significant byte.
- R6: After the result bytes, and within the same csb-low interval, the block sends 0x10, then the status upper address byte, then the instruction {1'b1, 2'b00, 1'b0, STS_ADDR[3:0]} (0x10, 0x01, 0x89 by default), then one zero byte. That makes 10 bytes (80 sclk cycles) per exchange. csb is low whenever a byte is being shifted.
- R7: If the status byte equals STALE_CODE (0x01), err_stale is set, result_vld stays low and result keeps its old value.
- R8: For any other status byte, result takes the assembled value and result_vld pulses high for exactly one cycle. err_stale is low at that point.
- R9: If no falling edge on miso arrives within TIMEOUT cycles of waiting, csb returns high, timeout is set, and no sclk edge occurs. timeout and err_stale hold until the next data-ready edge is accepted, which clears both.
- R10: After a completed exchange, csb stays high for at least GAP_CYC cycles before it goes low again.
- R11: While enable is low in idle, csb stays high and sclk does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Allows readouts to start; sampled in idle |
| miso | input | 1 | Converter data-out; also carries data-ready (low = ready) |
| sclk | output | 1 | Serial clock, idles high |
| csb | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to converter |
| result | output | 24 | Last accepted conversion result (8*RES_BYTES) |
| result_vld | output | 1 | One-cycle strobe when result is updated |
| err_stale | output | 1 | Status reported a not-ready or repeated result |
| timeout | output | 1 | No data-ready edge arrived in time |

## Verification
The assertions assume that miso settles within the synchronizer delay after a falling sclk edge, which in turn requires HALF_DIV to be at least 4. They also assume that the converter holds data-out high while it is deselected, so that entering the wait state never produces a spurious falling edge. The bench slave model meets both assumptions: it acts on falling sclk at the half-cycle and forces miso high whenever csb is high. It drops miso to signal data-ready only while the block waits, after a delay taken from each vector, or never when the test is the timeout case.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;

  // first byte of every access: write to the upper-address register
  localparam logic [7:0] URA_WR_INSTR = 8'h10;

  function automatic logic [7:0] ura_byte(input logic [6:0] addr);
    return {5'b00000, addr[6:4]};
  endfunction

  function automatic logic [7:0] rd_instr(input logic [6:0] addr, input logic [1:0] size_m1);
    return {1'b1, size_m1, 1'b0, addr[3:0]};
  endfunction

endpackage

// File: rtl/miso_sync.sv
module miso_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic miso_i,
  output logic miso_s,
  output logic miso_fall
);
  logic [2:0] sync_q;
  logic [2:0] sync_d;

  always_comb begin
    sync_d = {sync_q[1:0], miso_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= sync_d;
  end

  assign miso_s    = sync_q[1];
  assign miso_fall = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/spi_byte_eng.sv
module spi_byte_eng #(
  parameter int HALF_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso_s,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          busy_q, busy_d;
  logic          sclk_q, sclk_d;
  logic          mosi_q, mosi_d;
  logic          done_q, done_d;
  logic [7:0]    txs_q, txs_d;
  logic [7:0]    rxs_q, rxs_d;
  logic [3:0]    bit_q, bit_d;
  logic [DW-1:0] div_q, div_d;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    bit_d  = bit_q;
    div_d  = div_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sclk_d = 1'b0;
        mosi_d = tx_byte[7];
        txs_d  = {tx_byte[6:0], 1'b0};
        bit_d  = 4'd0;
        div_d  = '0;
      end
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rxs_d  = {rxs_q[6:0], miso_s};
        bit_d  = bit_q + 4'd1;
      end else if (bit_q == 4'd8) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        sclk_d = 1'b0;
        mosi_d = txs_q[7];
        txs_d  = {txs_q[6:0], 1'b0};
      end
    end else begin
      div_d = div_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      txs_q  <= '0;
      rxs_q  <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rxs_q;

  // R2: sclk idles high whenever no byte is shifting
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sclk_q);
  // R2: mosi only moves together with a falling sclk edge
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_q));
  // R2: never more than eight rising edges per byte
  assert_bit_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= 4'd8);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_rdout_pkg::*;
#(
  parameter int         RES_BYTES  = 3,
  parameter logic [6:0] DATA_ADDR  = 7'h1A,
  parameter logic [6:0] STS_ADDR   = 7'h19,
  parameter logic [7:0] STALE_CODE = 8'h01,
  parameter int         TIMEOUT    = 100000,
  parameter int         GAP_CYC    = 7200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   miso_fall,
  input  logic                   eng_done,
  input  logic [7:0]             rx_byte,
  output logic                   csb,
  output logic                   eng_start,
  output logic [7:0]             tx_byte,
  output logic [8*RES_BYTES-1:0] result,
  output logic                   result_vld,
  output logic                   err_stale,
  output logic                   timeout
);
  localparam int RES_W = 8 * RES_BYTES;
  localparam int NSEQ  = 7 + RES_BYTES;
  localparam int IW    = $clog2(NSEQ);
  localparam int CMAX  = (TIMEOUT > GAP_CYC) ? TIMEOUT : GAP_CYC;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NSEQ - 1);
  localparam logic [IW-1:0] IDX_D_LO = IW'(3);
  localparam logic [IW-1:0] IDX_D_HI = IW'(2 + RES_BYTES);

  seq_state_e       state_q, state_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             kick_q, kick_d;
  logic             csb_q, csb_d;
  logic             vld_q, vld_d;
  logic             err_q, err_d;
  logic             to_q, to_d;
  logic [RES_W-1:0] acc_q, acc_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             in_data;

  // byte to send for the current sequence slot
  always_comb begin
    tx_byte = 8'h00;
    if (idx_q == IW'(0) || idx_q == IW'(NSEQ - 4))
      tx_byte = URA_WR_INSTR;
    else if (idx_q == IW'(1))
      tx_byte = ura_byte(DATA_ADDR);
    else if (idx_q == IW'(NSEQ - 3))
      tx_byte = ura_byte(STS_ADDR);
    else if (idx_q == IW'(2))
      tx_byte = rd_instr(DATA_ADDR, 2'(RES_BYTES - 1));
    else if (idx_q == IW'(NSEQ - 2))
      tx_byte = rd_instr(STS_ADDR, 2'd0);
  end

  assign in_data = (idx_q >= IDX_D_LO) && (idx_q <= IDX_D_HI);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    kick_d  = 1'b0;
    vld_d   = 1'b0;
    err_d   = err_q;
    to_d    = to_q;
    acc_d   = acc_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE: begin
        if (enable) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
      end
      ST_WAIT: begin
        if (miso_fall) begin
          state_d = ST_XFER;
          idx_d   = '0;
          kick_d  = 1'b1;
          err_d   = 1'b0;
          to_d    = 1'b0;
        end else if (cnt_q == CW'(TIMEOUT - 1)) begin
          state_d = ST_IDLE;
          to_d    = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_XFER: begin
        if (eng_done) begin
          if (in_data) acc_d = (acc_q << 8) | RES_W'(rx_byte);
          if (idx_q == IDX_LAST) begin
            state_d = ST_GAP;
            cnt_d   = '0;
            if (rx_byte == STALE_CODE) begin
              err_d = 1'b1;
            end else begin
              vld_d = 1'b1;
              res_d = acc_q;
            end
          end else begin
            idx_d  = idx_q + IW'(1);
            kick_d = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (cnt_q == CW'(GAP_CYC - 1)) state_d = ST_IDLE;
        else                           cnt_d   = cnt_q + CW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
    csb_d = (state_d == ST_IDLE) || (state_d == ST_GAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      kick_q  <= 1'b0;
      csb_q   <= 1'b1;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      to_q    <= 1'b0;
      acc_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      kick_q  <= kick_d;
      csb_q   <= csb_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
      to_q    <= to_d;
      acc_q   <= acc_d;
      res_q   <= res_d;
    end
  end

  assign csb        = csb_q;
  assign eng_start  = kick_q;
  assign result     = res_q;
  assign result_vld = vld_q;
  assign err_stale  = err_q;
  assign timeout    = to_q;

  // R7: a stale status never comes with a valid strobe
  assert_vld_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && err_q));
  // R8: valid is a single-cycle strobe
  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R9: waiting never runs past the timeout limit
  assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q < CW'(TIMEOUT)));
  // R7: the result register holds whenever no strobe is issued
  assert_res_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(res_q));
endmodule

// File: rtl/adc_rdout_seq.sv
module adc_rdout_seq #(
  parameter int         HALF_DIV   = 64,
  parameter int         RES_BYTES  = 3,
  parameter logic [6:0] DATA_ADDR  = 7'h1A,
  parameter logic [6:0] STS_ADDR   = 7'h19,
  parameter logic [7:0] STALE_CODE = 8'h01,
  parameter int         TIMEOUT    = 100000,
  parameter int         GAP_CYC    = 7200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   miso,
  output logic                   sclk,
  output logic                   csb,
  output logic                   mosi,
  output logic [8*RES_BYTES-1:0] result,
  output logic                   result_vld,
  output logic                   err_stale,
  output logic                   timeout
);
  logic [1:0] rsync_q;
  logic       srst_n;
  logic       miso_s, miso_fall;
  logic       eng_start, eng_busy, eng_done;
  logic [7:0] tx_byte, rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  miso_sync u_sync (
    .clk       (clk),
    .rst_n     (srst_n),
    .miso_i    (miso),
    .miso_s    (miso_s),
    .miso_fall (miso_fall)
  );

  spi_byte_eng #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (eng_start),
    .tx_byte (tx_byte),
    .miso_s  (miso_s),
    .sclk    (sclk),
    .mosi    (mosi),
    .busy    (eng_busy),
    .done    (eng_done),
    .rx_byte (rx_byte)
  );

  seq_ctrl #(
    .RES_BYTES  (RES_BYTES),
    .DATA_ADDR  (DATA_ADDR),
    .STS_ADDR   (STS_ADDR),
    .STALE_CODE (STALE_CODE),
    .TIMEOUT    (TIMEOUT),
    .GAP_CYC    (GAP_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .enable     (enable),
    .miso_fall  (miso_fall),
    .eng_done   (eng_done),
    .rx_byte    (rx_byte),
    .csb        (csb),
    .eng_start  (eng_start),
    .tx_byte    (tx_byte),
    .result     (result),
    .result_vld (result_vld),
    .err_stale  (err_stale),
    .timeout    (timeout)
  );

  // R6: bytes only shift while the converter is selected
  assert_csb_busy_R6: assert property (@(posedge clk) disable iff (!srst_n)
    eng_busy |-> !csb);
  // R3: no clock activity while deselected
  assert_sclk_desel_R3: assert property (@(posedge clk) disable iff (!srst_n)
    csb |-> sclk);
  // R9: a timeout leaves the converter deselected
  assert_to_desel_R9: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(timeout) |-> csb);
endmodule

// File: tb/sim_adc_rdout_seq.sv
module sim_adc_rdout_seq;
  localparam int CLK_P    = 10;
  localparam int HALF_DIV = 4;
  localparam int TIMEOUT  = 200;
  localparam int GAP_CYC  = 30;
  localparam int NB       = 10;
  localparam int NVEC     = 6;
  // {result[23:0], status[7:0], ready delay[7:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {24'hA5C30F, 8'h00, 8'd5},
    {24'h000001, 8'h00, 8'd0},
    {24'hFFFFFF, 8'h01, 8'd12},
    {24'h800000, 8'h00, 8'd3},
    {24'h7FFFFE, 8'h04, 8'd20},
    {24'h123456, 8'h01, 8'd1}
  };

  logic clk, rst_n, enable, miso;
  logic sclk, csb, mosi, result_vld, err_stale, timeout;
  logic [23:0] result;

  adc_rdout_seq #(
    .HALF_DIV(HALF_DIV), .RES_BYTES(3), .DATA_ADDR(7'h1A), .STS_ADDR(7'h19),
    .STALE_CODE(8'h01), .TIMEOUT(TIMEOUT), .GAP_CYC(GAP_CYC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .miso(miso),
    .sclk(sclk), .csb(csb), .mosi(mosi), .result(result),
    .result_vld(result_vld), .err_stale(err_stale), .timeout(timeout)
  );

  int total = 0;
  int bad   = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // slave model state (written only by the model process)
  logic [7:0] resp [NB];
  int   rdy_delay;
  logic [7:0] got [NB];
  logic [7:0] rx_sh;
  int   fall_n, rise_n, wait_cnt, last_bits, done_n, vld_n;
  int   csb_falls, sclk_falls, pre_edges, low_len, low_min, low_max;
  int   hi_len, gap_min, cyc;
  bit   prev_csb, prev_sclk, rdy_given, had_xfer;
  logic [23:0] last_res;

  initial begin
    miso = 1'b1;
    fall_n = 0; rise_n = 0; wait_cnt = 0; last_bits = 0; done_n = 0; vld_n = 0;
    csb_falls = 0; sclk_falls = 0; pre_edges = 0; low_len = 0;
    low_min = 1000; low_max = 0; hi_len = 0; gap_min = 1000; cyc = 0;
    prev_csb = 1'b1; prev_sclk = 1'b1; rdy_given = 1'b0; had_xfer = 1'b0;
    last_res = '0; rx_sh = '0;
    for (int i = 0; i < NB; i++) got[i] = 8'h00;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n === 1'b1) begin
      if (prev_csb && !csb) begin
        csb_falls++;
        if (had_xfer && hi_len < gap_min) gap_min = hi_len;
        fall_n = 0; rise_n = 0; wait_cnt = 0; rdy_given = 1'b0;
      end
      if (!prev_csb && csb) begin
        last_bits = rise_n;
        had_xfer  = (rise_n > 0);
        if (rise_n > 0) done_n++;
        hi_len = 0;
      end
      if (result_vld) begin vld_n++; last_res = result; end
      if (prev_sclk && !sclk) sclk_falls++;
      if (csb) begin
        miso = 1'b1;
        hi_len++;
      end else begin
        if (!rdy_given) begin
          if (prev_sclk && !sclk) pre_edges++;
          if (rdy_delay >= 0 && wait_cnt == rdy_delay) begin
            miso = 1'b0;
            rdy_given = 1'b1;
          end
          wait_cnt++;
        end
        if (prev_sclk && !sclk) begin
          if (fall_n / 8 < NB) miso = resp[fall_n / 8][7 - (fall_n % 8)];
          fall_n++;
        end
        if (!sclk) low_len++;
        if (!prev_sclk && sclk) begin
          if (low_len < low_min) low_min = low_len;
          if (low_len > low_max) low_max = low_len;
          low_len = 0;
          rx_sh = {rx_sh[6:0], mosi};
          rise_n++;
          if (rise_n % 8 == 0 && rise_n / 8 <= NB) got[rise_n / 8 - 1] = rx_sh;
        end
      end
      prev_csb  = csb;
      prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_resp(input logic [23:0] r, input logic [7:0] s);
    for (int i = 0; i < NB; i++) resp[i] = 8'h00;
    resp[3] = r[23:16];
    resp[4] = r[15:8];
    resp[5] = r[7:0];
    resp[9] = s;
  endtask

  task automatic wait_done(input int prev, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done_n > prev) begin ok = 1'b1; break; end
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] exp_res;
    bit ok;
    int prev, vprev;
    rdy_delay = -1;
    set_resp(24'h0, 8'h0);
    enable = 1'b0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(csb == 1'b1, "R1 csb", 32'(csb), 1);
    chk(sclk == 1'b1, "R1 sclk", 32'(sclk), 1);
    chk(result_vld == 1'b0, "R1 vld", 32'(result_vld), 0);
    chk(err_stale == 1'b0, "R1 err", 32'(err_stale), 0);
    chk(timeout == 1'b0, "R1 timeout", 32'(timeout), 0);
    chk(result == 24'h0, "R1 result", 32'(result), 0);

    // R11 disabled: nothing moves
    repeat (60) @(negedge clk);
    chk(csb_falls == 0, "R11 csb falls", 32'(csb_falls), 0);
    chk(sclk_falls == 0, "R11 sclk edges", 32'(sclk_falls), 0);

    // R9 timeout: data-ready never comes
    enable = 1'b1;
    ok = 1'b0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (timeout) begin ok = 1'b1; break; end
    end
    enable = 1'b0;
    chk(ok, "R9 timeout raised", 32'(ok), 1);
    chk(csb == 1'b1, "R9 csb high after timeout", 32'(csb), 1);
    chk(sclk_falls == 0, "R9 R3 no sclk while waiting", 32'(sclk_falls), 0);
    repeat (10) @(negedge clk);
    chk(timeout == 1'b1, "R9 timeout held", 32'(timeout), 1);

    // vector table
    exp_res = 24'h0;
    for (int v = 0; v < NVEC; v++) begin
      set_resp(VEC[v][39:16], VEC[v][15:8]);
      rdy_delay = int'(VEC[v][7:0]);
      prev  = done_n;
      vprev = vld_n;
      enable = 1'b1;
      wait_done(prev, ok);
      if (v == NVEC - 1) enable = 1'b0;
      chk(ok, "R6 exchange completed", 32'(ok), 1);
      chk(last_bits == 8 * NB, "R6 bit count", 32'(last_bits), 32'(8 * NB));
      chk(got[0] == 8'h10 && got[1] == 8'h01 && got[2] == 8'hCA, "R4 result access bytes",
          {8'h0, got[0], got[1], got[2]}, 32'h0010_01CA);
      chk(got[3] == 8'h00 && got[4] == 8'h00 && got[5] == 8'h00, "R5 zero data bytes",
          {8'h0, got[3], got[4], got[5]}, 32'h0);
      chk(got[6] == 8'h10 && got[7] == 8'h01 && got[8] == 8'h89 && got[9] == 8'h00,
          "R6 status access bytes", {got[6], got[7], got[8], got[9]}, 32'h1001_8900);
      chk(timeout == 1'b0, "R9 timeout cleared by start", 32'(timeout), 0);
      chk(pre_edges == 0, "R3 no sclk before ready", 32'(pre_edges), 0);
      if (VEC[v][15:8] == 8'h01) begin
        chk(err_stale == 1'b1, "R7 stale flag", 32'(err_stale), 1);
        chk(vld_n == vprev, "R7 no strobe", 32'(vld_n), 32'(vprev));
        chk(result == exp_res, "R7 result kept", 32'(result), 32'(exp_res));
      end else begin
        exp_res = VEC[v][39:16];
        chk(err_stale == 1'b0, "R8 err low", 32'(err_stale), 0);
        chk(vld_n == vprev + 1, "R8 one strobe", 32'(vld_n), 32'(vprev + 1));
        chk(last_res == exp_res && result == exp_res, "R8 R5 result value",
            32'(last_res), 32'(exp_res));
      end
    end

    repeat (GAP_CYC + 20) @(negedge clk);
    chk(csb == 1'b1, "R11 idle after disable", 32'(csb), 1);
    chk(gap_min >= GAP_CYC, "R10 min gap", 32'(gap_min), 32'(GAP_CYC));
    chk(low_min == HALF_DIV && low_max == HALF_DIV, "R2 low phase length",
        32'(low_max), 32'(HALF_DIV));
    chk(low_min == HALF_DIV, "R2 low phase min", 32'(low_min), 32'(HALF_DIV));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule